// File: doc/BRIEF.md
# Coprocessor Port Window Decoder

This block sits on a simple host I/O bus and claims a 16-port window that starts at port 0xF0 (0xF0 through 0xFF), where a legacy math coprocessor used to be controlled. It does not execute coprocessor opcodes. Its job is to keep two pieces of coprocessor state: a busy latch and an error interrupt line (interrupt request 13 toward the interrupt controller). It also pulses a coprocessor reset output and reports every access it cannot honour on a one-cycle unsupported-access flag.

A separate error-event input stands in for the coprocessor reporting a fault. It sets the busy latch and raises the interrupt line. Software then writes single bytes into the window. Port 0xF0 clears the busy latch. Port 0xF1 resets the coprocessor, which also clears busy. Any byte write in the window drops the interrupt line. Opcode-transfer ports and every other window port are unsupported. Non-byte writes and all reads in the window are also unsupported. A window read returns an all-ones data value, which is the unused-port value. All outputs are registered and respond in the clock cycle after the access.

Top module: `copro_port_decoder`

## Requirements
- R1: After reset, busyOut, irq13, coproReset and unsupFlag are 0 and ioRData is 0x00.
- R2: An access hits the window only when all 16 address bits lie between 0xF0 and 0xFF inclusive. An access outside the window changes no output: busyOut and irq13 keep their values, coproReset and unsupFlag stay 0, and ioRData reads 0x00.
- R3: A byte write (ioWr=1, ioByte=1) to port 0xF0 clears busyOut in the next cycle and raises neither coproReset nor unsupFlag.
- R4: A byte write to port 0xF1 makes coproReset high for exactly the next cycle and clears busyOut.
- R5: A byte write to any window port other than 0xF0 and 0xF1 leaves busyOut unchanged and pulses unsupFlag in the next cycle. This covers the opcode-transfer ports 0xF8, 0xFA and 0xFC.
- R6: Every byte write that hits the window clears irq13 in the next cycle, whatever the port.
- R7: A write with ioByte=0 that hits the window leaves busyOut and irq13 unchanged, gives no coproReset, and pulses unsupFlag in the next cycle.
- R8: A read (ioRd=1) that hits the window returns 0xFF on ioRData and pulses unsupFlag in the next cycle. A read outside the window returns 0x00 and gives no flag.
- R9: When errEvent is high, busyOut and irq13 are 1 in the next cycle. This holds even if a clearing write arrives in the same cycle.
- R10: coproReset and unsupFlag return to 0 in the cycle after an idle bus cycle, so each access yields a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O port address |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioByte | input | 1 | 1 when the access is a single byte |
| ioWData | input | 8 | Write data (not interpreted) |
| ioRData | output | 8 | Read data, valid the cycle after a read |
| errEvent | input | 1 | Coprocessor error: sets busy and the interrupt |
| busyOut | output | 1 | Coprocessor busy latch |
| irq13 | output | 1 | Error interrupt request to the interrupt controller |
| coproReset | output | 1 | Single-cycle coprocessor reset pulse |
| unsupFlag | output | 1 | Single-cycle unsupported-access pulse |

## Verification
The assertions assume that the host never raises ioWr and ioRd in the same cycle, and one of them checks this. The bench drives at most one strobe per access and then leaves the bus idle for a cycle, so every pulse can be seen to fall. Before each access, errEvent pre-sets busy and the interrupt, which makes every clearing action visible. The bench sweeps byte writes, wide writes and reads across ports 0x000 to 0x1FF and over aliases in the upper address bits. It also drives errEvent in the same cycle as clearing writes.

// File: rtl/copro_pkg.sv
package copro_pkg;

  // Strobes from the decode control to the state datapath
  typedef struct packed {
    logic clrBusy;   // drop busy latch
    logic clrIrq;    // drop interrupt line
    logic rstPulse;  // issue coprocessor reset
    logic unsup;     // access cannot be honoured
    logic rdHit;     // read inside window
  } ctlStrobes_t;

endpackage

// File: rtl/copro_ctl.sv
module copro_ctl
  import copro_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h00F0,
  parameter int CLR_OFF = 0,
  parameter int RST_OFF = 1
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              ioByte,
  output ctlStrobes_t       strb
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];
  localparam logic [WIN_LOG2-1:0] CLR_IDX = WIN_LOG2'(CLR_OFF);
  localparam logic [WIN_LOG2-1:0] RST_IDX = WIN_LOG2'(RST_OFF);

  logic                winHit;
  logic [WIN_LOG2-1:0] offset;
  logic                wrByte;
  logic                wrWide;
  logic                isClr;
  logic                isRst;

  always_comb begin
    winHit = (ioAddr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
    offset = ioAddr[WIN_LOG2-1:0];
    wrByte = ioWr && ioByte && winHit;
    wrWide = ioWr && !ioByte && winHit;
    isClr  = (offset == CLR_IDX);
    isRst  = (offset == RST_IDX);

    strb.clrIrq   = wrByte;
    strb.clrBusy  = wrByte && (isClr || isRst);
    strb.rstPulse = wrByte && isRst;
    strb.rdHit    = ioRd && winHit;
    strb.unsup    = (wrByte && !(isClr || isRst)) || wrWide || strb.rdHit;
  end

endmodule

// File: rtl/copro_dp.sv
module copro_dp
  import copro_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              errEvent,
  output logic [DATA_W-1:0] ioRData,
  output logic              busyOut,
  output logic              irq13,
  output logic              coproReset,
  output logic              unsupFlag
);

  localparam logic [DATA_W-1:0] UNUSED_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyOut    <= 1'b0;
      irq13      <= 1'b0;
      coproReset <= 1'b0;
      unsupFlag  <= 1'b0;
      ioRData    <= '0;
    end else begin
      // error event has priority over clears
      if (errEvent)          busyOut <= 1'b1;
      else if (strb.clrBusy) busyOut <= 1'b0;
      if (errEvent)          irq13 <= 1'b1;
      else if (strb.clrIrq)  irq13 <= 1'b0;
      coproReset <= strb.rstPulse;
      unsupFlag  <= strb.unsup;
      ioRData    <= strb.rdHit ? UNUSED_VAL : '0;
    end
  end

endmodule

// File: rtl/copro_port_decoder.sv
module copro_port_decoder
  import copro_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h00F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              ioByte,
  input  logic [DATA_W-1:0] ioWData,
  output logic [DATA_W-1:0] ioRData,
  input  logic              errEvent,
  output logic              busyOut,
  output logic              irq13,
  output logic              coproReset,
  output logic              unsupFlag
);

  ctlStrobes_t strb;
  logic        unusedData;

  assign unusedData = ^ioWData;

  copro_ctl #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE),
    .CLR_OFF(0), .RST_OFF(1)
  ) uCtl (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .ioByte(ioByte), .strb(strb)
  );

  copro_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .errEvent(errEvent),
    .ioRData(ioRData), .busyOut(busyOut), .irq13(irq13),
    .coproReset(coproReset), .unsupFlag(unsupFlag)
  );

endmodule

// File: rtl/copro_port_decoder_chk.sv
module copro_port_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h00F0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic              ioByte,
  input logic              errEvent,
  input logic [DATA_W-1:0] ioRData,
  input logic              busyOut,
  input logic              irq13,
  input logic              coproReset,
  input logic              unsupFlag
);

  logic hitC;
  assign hitC = (ioAddr >> WIN_LOG2) == (WIN_BASE >> WIN_LOG2);

  // bus assumption: one strobe at a time
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN) !(ioWr && ioRd));

  // R4
  rst_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coproReset) |-> $past(ioWr && ioByte && ioAddr == (WIN_BASE + 1)));

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioByte && hitC && !errEvent) |=> !irq13);

  // R7
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && !ioByte && hitC && !errEvent) |=> ($stable(busyOut) && $stable(irq13) && unsupFlag && !coproReset));

  // R8
  rd_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && hitC) |=> (unsupFlag && ioRData == '1));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> (busyOut && irq13));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hitC && !errEvent) |=> ($stable(busyOut) && $stable(irq13) && !unsupFlag && !coproReset));

  // R10
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ioWr && !ioRd) |=> (!unsupFlag && !coproReset));

endmodule

bind copro_port_decoder copro_port_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioByte(ioByte), .errEvent(errEvent), .ioRData(ioRData), .busyOut(busyOut),
  .irq13(irq13), .coproReset(coproReset), .unsupFlag(unsupFlag)
);

// File: tb/tb_copro_port_decoder.sv
module tb_copro_port_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic        ioByte = 1'b0;
  logic [7:0]  ioWData = '0;
  logic [7:0]  ioRData;
  logic        errEvent = 1'b0;
  logic        busyOut, irq13, coproReset, unsupFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  copro_port_decoder dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioByte(ioByte), .ioWData(ioWData), .ioRData(ioRData), .errEvent(errEvent),
    .busyOut(busyOut), .irq13(irq13), .coproReset(coproReset), .unsupFlag(unsupFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic preset();
    @(negedge clk);
    errEvent = 1'b1;
    step();
    chk("R9", "busy after error", busyOut, 1);
    chk("R9", "irq after error", irq13, 1);
    @(negedge clk);
    errEvent = 1'b0;
  endtask

  // kind: 0 byte write, 1 wide write, 2 read
  task automatic access(input logic [15:0] a, input int kind);
    bit hit, clrP, rstP;
    string tag;
    hit  = (a >= 16'h00F0) && (a <= 16'h00FF);
    clrP = (a == 16'h00F0);
    rstP = (a == 16'h00F1);
    preset();
    ioAddr = a;
    ioWr = (kind != 2);
    ioRd = (kind == 2);
    ioByte = (kind == 0);
    ioWData = a[7:0] ^ 8'h5A;
    step();
    if (!hit) begin
      chk("R2", "miss busy", busyOut, 1);
      chk("R2", "miss irq", irq13, 1);
      chk("R2", "miss flag", unsupFlag, 0);
      chk("R2", "miss reset", coproReset, 0);
      chk(kind == 2 ? "R8" : "R2", "miss rdata", ioRData, 0);
    end else if (kind == 0) begin
      tag = clrP ? "R3" : (rstP ? "R4" : "R5");
      chk("R6", "irq after byte write", irq13, 0);
      chk(tag, "busy after byte write", busyOut, (clrP || rstP) ? 0 : 1);
      chk(tag, "reset pulse", coproReset, rstP ? 1 : 0);
      chk(tag, "unsup flag", unsupFlag, (clrP || rstP) ? 0 : 1);
    end else if (kind == 1) begin
      chk("R7", "wide busy", busyOut, 1);
      chk("R7", "wide irq", irq13, 1);
      chk("R7", "wide reset", coproReset, 0);
      chk("R7", "wide flag", unsupFlag, 1);
    end else begin
      chk("R8", "read data", ioRData, 8'hFF);
      chk("R8", "read flag", unsupFlag, 1);
    end
    @(negedge clk);
    ioWr = 1'b0;
    ioRd = 1'b0;
    step();
    chk("R10", "flag falls", unsupFlag, 0);
    chk(rstP && kind == 0 ? "R4" : "R10", "reset falls", coproReset, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset busy", busyOut, 0);
    chk("R1", "reset irq", irq13, 0);
    chk("R1", "reset pulse", coproReset, 0);
    chk("R1", "reset flag", unsupFlag, 0);
    chk("R1", "reset rdata", ioRData, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 16'h200; a++)
        access(16'(a), k);

    // aliases in the upper address bits must miss
    for (int k = 0; k < 3; k++) begin
      access(16'h10F0, k);
      access(16'h80F1, k);
      access(16'hFFF8, k);
    end

    // R9: error in the same cycle as clearing writes
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      errEvent = 1'b1;
      ioAddr = 16'h00F0 + 16'(p);
      ioWr = 1'b1;
      ioByte = 1'b1;
      step();
      chk("R9", "busy wins over clear", busyOut, 1);
      chk("R9", "irq wins over clear", irq13, 1);
      @(negedge clk);
      errEvent = 1'b0;
      ioWr = 1'b0;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule